// File: doc/BRIEF.md
# Cable Port Power and Bias Control

This block controls the cable ports of a serial-bus physical layer, one port per bit. For each port it decides when the line transmitter and receiver may run and when the port drives its bias output. It reports a cable-not-active status taken straight from the incoming-bias detector, and it flags any change of the cable-connected input with a one-clock event. Each port has a three-state controller: disabled, running or suspended.

A suspended port carries no data traffic. Its bias detection and its connection watch keep working while it is suspended. A global power-down, a held reset or a link-layer disable forces the port back to the disabled state. When the port is released it returns to running, not to suspended. Reset takes effect at once. Its release is synchronised to the clock before the state registers leave the disabled state.

Top module: `cable_port_ctrl`

## Requirements
- R1: For each port i, bit i of `tx_en` and bit i of `rx_en` are 1 exactly when the port is running, `pd` is 0, `cable_conn[i]` is 1 and `arb_dis[i]` is 0. These outputs are combinational in the inputs, so dropping any enabling input clears them in the same cycle.
- R2: For each port i, `bias_en[i]` is 1 exactly when the port is not in the disabled state, `pd` is 0 and `link_dis[i]` is 0. A suspended port keeps its bias enable.
- R3: `cna[i]` always equals the inverse of `bias_det[i]`, with no filtering and no register. This holds in every state, including power-down and reset.
- R4: `suspended[i]` is 1 exactly when port i is suspended. While it is suspended, `tx_en[i]` and `rx_en[i]` are 0, and `cna` and `conn_chg` keep working.
- R5: A running port with `susp_req[i]` high at a clock edge is suspended after that edge, unless `pd` or `link_dis[i]` is high at that edge.
- R6: A suspended port returns to running after an edge at which `resume_req[i]` is high, or at which `bias_det[i]` is 1 while it was 0 at the previous edge.
- R7: `conn_chg[i]` is high for exactly the one cycle after an edge that samples `cable_conn[i]` different from its value at the previous edge. This holds in every state. The first edge after reset release raises no event.
- R8: A low `rst_n` puts every port in the disabled state at once, and all enables read 0. After `rst_n` rises, the ports stay disabled for SYNC_STAGES edges and then go to running at the next edge.
- R9: Any edge that samples `pd` high, or `link_dis[i]` high, leaves port i disabled, even if it was suspended. The first edge at which both are low moves it from disabled to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts at once, released in sync with the clock |
| pd | input | 1 | Power-down, shared by all ports |
| cable_conn | input | NPORTS | Cable-connected status, one bit per port |
| bias_det | input | NPORTS | Incoming bias detected, one bit per port |
| arb_dis | input | NPORTS | Disable request from arbitration |
| link_dis | input | NPORTS | Port disable commanded by the link layer |
| susp_req | input | NPORTS | Suspend request |
| resume_req | input | NPORTS | Resume request |
| tx_en | output | NPORTS | Transmitter enable |
| rx_en | output | NPORTS | Receiver enable |
| bias_en | output | NPORTS | Bias output enable |
| cna | output | NPORTS | Cable not active (no incoming bias) |
| conn_chg | output | NPORTS | One-clock connection-change event |
| suspended | output | NPORTS | Port is in the suspended state |

## Verification
Results fall due at three different times:
- **Same cycle:** `cna` and the gating by `pd`, `arb_dis`, `link_dis` and `cable_conn` respond within the cycle in which the input changes.
- **After one edge:** state moves (suspend, resume, power-down, enable) show up after the clock edge that samples the request. `conn_chg` rises after the edge that samples the new cable level and falls at the following edge.
- **Reset release:** the enables come back SYNC_STAGES+1 edges after `rst_n` rises.

The bench drives all inputs at the falling edge and checks every output shortly after. Its reference model advances only at rising edges, so each check compares the outputs with the state that the edges seen so far imply.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_RUN   = 2'd1,
        PS_SLEEP = 2'd2
    } port_state_e;

    typedef struct packed {
        port_state_e st;
        logic        bias_q;
    } fsm_regs_t;

    typedef struct packed {
        logic seen;
        logic level;
        logic chg;
    } watch_regs_t;

endpackage

// File: rtl/cpc_rst_sync.sv
module cpc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = (sh_q << 1) | STAGES'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/cpc_port_fsm.sv
module cpc_port_fsm
    import cpc_pkg::*;
(
    input  logic        clk,
    input  logic        arst_n,
    input  logic        pd,
    input  logic        link_dis,
    input  logic        susp_req,
    input  logic        resume_req,
    input  logic        bias_det,
    output port_state_e state
);
    fsm_regs_t r_d, r_q;
    logic      bias_rise;

    always_comb begin
        r_d       = r_q;
        bias_rise = bias_det && !r_q.bias_q;
        r_d.bias_q = bias_det;
        if (pd || link_dis) begin
            r_d.st = PS_OFF;
        end else begin
            case (r_q.st)
                PS_OFF:   r_d.st = PS_RUN;
                PS_RUN:   if (susp_req) r_d.st = PS_SLEEP;
                PS_SLEEP: if (resume_req || bias_rise) r_d.st = PS_RUN;
                default:  r_d.st = PS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            r_q.st     <= PS_OFF;
            r_q.bias_q <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;
endmodule

// File: rtl/cpc_conn_watch.sv
module cpc_conn_watch
    import cpc_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic conn,
    output logic chg
);
    watch_regs_t w_d, w_q;

    always_comb begin
        w_d       = w_q;
        w_d.seen  = 1'b1;
        w_d.level = conn;
        w_d.chg   = w_q.seen && (conn != w_q.level);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) w_q <= '0;
        else         w_q <= w_d;
    end

    assign chg = w_q.chg;
endmodule

// File: rtl/cpc_port_out.sv
module cpc_port_out
    import cpc_pkg::*;
(
    input  port_state_e state,
    input  logic        pd,
    input  logic        conn,
    input  logic        arb_dis,
    input  logic        link_dis,
    output logic        tx_en,
    output logic        rx_en,
    output logic        bias_en,
    output logic        susp
);
    logic line_ok;

    always_comb begin
        line_ok = (state == PS_RUN) && !pd && conn && !arb_dis;
        tx_en   = line_ok;
        rx_en   = line_ok;
        bias_en = (state != PS_OFF) && !pd && !link_dis;
        susp    = (state == PS_SLEEP);
    end
endmodule

// File: rtl/cable_port_ctrl.sv
module cable_port_ctrl
    import cpc_pkg::*;
#(
    parameter int NPORTS      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd,
    input  logic [NPORTS-1:0] cable_conn,
    input  logic [NPORTS-1:0] bias_det,
    input  logic [NPORTS-1:0] arb_dis,
    input  logic [NPORTS-1:0] link_dis,
    input  logic [NPORTS-1:0] susp_req,
    input  logic [NPORTS-1:0] resume_req,
    output logic [NPORTS-1:0] tx_en,
    output logic [NPORTS-1:0] rx_en,
    output logic [NPORTS-1:0] bias_en,
    output logic [NPORTS-1:0] cna,
    output logic [NPORTS-1:0] conn_chg,
    output logic [NPORTS-1:0] suspended
);
    logic rst_sync_n;

    cpc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_sync_n (rst_sync_n)
    );

    // R3: cable-not-active follows the detector directly
    assign cna = ~bias_det;

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        port_state_e st;

        cpc_port_fsm u_fsm (
            .clk        (clk),
            .arst_n     (rst_sync_n),
            .pd         (pd),
            .link_dis   (link_dis[i]),
            .susp_req   (susp_req[i]),
            .resume_req (resume_req[i]),
            .bias_det   (bias_det[i]),
            .state      (st)
        );

        cpc_conn_watch u_watch (
            .clk    (clk),
            .arst_n (rst_sync_n),
            .conn   (cable_conn[i]),
            .chg    (conn_chg[i])
        );

        cpc_port_out u_out (
            .state    (st),
            .pd       (pd),
            .conn     (cable_conn[i]),
            .arb_dis  (arb_dis[i]),
            .link_dis (link_dis[i]),
            .tx_en    (tx_en[i]),
            .rx_en    (rx_en[i]),
            .bias_en  (bias_en[i]),
            .susp     (suspended[i])
        );
    end
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
    parameter int NPORTS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pd,
    input logic [NPORTS-1:0] cable_conn,
    input logic [NPORTS-1:0] link_dis,
    input logic [NPORTS-1:0] susp_req,
    input logic [NPORTS-1:0] resume_req,
    input logic [NPORTS-1:0] tx_en,
    input logic [NPORTS-1:0] rx_en,
    input logic [NPORTS-1:0] bias_en,
    input logic [NPORTS-1:0] conn_chg,
    input logic [NPORTS-1:0] suspended
);
    p_pd_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> ((tx_en | rx_en | bias_en) == '0));

    p_no_cable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_en | rx_en) & ~cable_conn) == '0);

    p_link_bias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (link_dis & bias_en) == '0);

    p_susp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended & (tx_en | rx_en)) == '0);

    p_susp_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended & ~$past(suspended) & ~$past(susp_req)) == '0);

    p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended & $past(suspended & resume_req)) == '0);

    p_chg_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_chg & ~($past(cable_conn) ^ $past(cable_conn, 2))) == '0);

    p_pd_leaves_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pd) |-> (suspended == '0));
endmodule

bind cable_port_ctrl cpc_checker #(.NPORTS(NPORTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd         (pd),
    .cable_conn (cable_conn),
    .link_dis   (link_dis),
    .susp_req   (susp_req),
    .resume_req (resume_req),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .bias_en    (bias_en),
    .conn_chg   (conn_chg),
    .suspended  (suspended)
);

// File: tb/tb_cable_port_ctrl.sv
module tb_cable_port_ctrl;
    localparam int NP  = 2;
    localparam int STG = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          pd = 1'b0;
    logic [NP-1:0] cc = '1, bd = '0, arb = '0, link = '0, sreq = '0, rreq = '0;
    logic [NP-1:0] tx, rx, bias, cna, chg, susp;

    cable_port_ctrl #(.NPORTS(NP), .SYNC_STAGES(STG)) dut (
        .clk(clk), .rst_n(rst_n), .pd(pd), .cable_conn(cc), .bias_det(bd),
        .arb_dis(arb), .link_dis(link), .susp_req(sreq), .resume_req(rreq),
        .tx_en(tx), .rx_en(rx), .bias_en(bias), .cna(cna), .conn_chg(chg),
        .suspended(susp)
    );

    // reference model: 0 off, 1 running, 2 suspended
    int   mst [NP];
    logic m_bq [NP], m_cq [NP], m_seen [NP], m_chg [NP];
    int   rcnt = 0;
    int   checks = 0, fails = 0;
    bit   done = 0;

    task automatic model_reset();
        for (int i = 0; i < NP; i++) begin
            mst[i] = 0; m_bq[i] = 0; m_cq[i] = 0; m_seen[i] = 0; m_chg[i] = 0;
        end
    endtask

    task automatic model_edge();
        bit ok = (rcnt >= STG);
        for (int i = 0; i < NP; i++) begin
            if (!ok) begin
                mst[i] = 0; m_bq[i] = 0; m_cq[i] = 0; m_seen[i] = 0; m_chg[i] = 0;
            end else begin
                m_chg[i]  = m_seen[i] && (cc[i] != m_cq[i]);
                m_cq[i]   = cc[i];
                m_seen[i] = 1;
                if (pd || link[i]) mst[i] = 0;
                else if (mst[i] == 0) mst[i] = 1;
                else if (mst[i] == 1) begin
                    if (sreq[i]) mst[i] = 2;
                end else begin
                    if (rreq[i] || (bd[i] && !m_bq[i])) mst[i] = 1;
                end
                m_bq[i] = bd[i];
            end
        end
        if (!rst_n) rcnt = 0;
        else if (rcnt < STG) rcnt++;
    endtask

    task automatic check(string req, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] e_tx();
        for (int i = 0; i < NP; i++) e_tx[i] = (mst[i] == 1) && !pd && cc[i] && !arb[i];
    endfunction
    function automatic logic [NP-1:0] e_bias();
        for (int i = 0; i < NP; i++) e_bias[i] = (mst[i] != 0) && !pd && !link[i];
    endfunction
    function automatic logic [NP-1:0] e_susp();
        for (int i = 0; i < NP; i++) e_susp[i] = (mst[i] == 2);
    endfunction
    function automatic logic [NP-1:0] e_chg();
        for (int i = 0; i < NP; i++) e_chg[i] = m_chg[i];
    endfunction

    task automatic check_all(string tag);
        #1;
        check({"R1 ", tag}, "tx_en", tx, e_tx());
        check({"R1 ", tag}, "rx_en", rx, e_tx());
        check({"R2 ", tag}, "bias_en", bias, e_bias());
        check({"R3 ", tag}, "cna", cna, ~bd);
        check({"R7 ", tag}, "conn_chg", chg, e_chg());
        check({"R4 ", tag}, "suspended", susp, e_susp());
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        model_reset();
        @(negedge clk);
        // R8: reset state, R3 cna live during reset
        bd = 2'b01;
        check_all("R8 reset");
        check("R8", "tx in reset", tx, '0);
        check("R3", "cna in reset", cna, 2'b10);
        step();
        rst_n = 1'b1;
        for (int k = 0; k < STG; k++) begin
            check_all("R8 release");
            step();
        end
        check("R8", "still off before run", tx, '0);
        step();
        check_all("R8 run after release");
        check("R8", "running after sync", tx, 2'b11);

        // R5: suspend port 0, R4 data blocked while suspended
        bd = 2'b00; sreq = 2'b01; step(); sreq = '0;
        check_all("R5 suspend");
        check("R5", "port0 suspended", susp, 2'b01);
        check("R4", "tx blocked", tx, 2'b10);
        // R7 + R4: connection change seen while suspended
        cc = 2'b10; step(); check_all("R7 change");
        check("R7", "pulse while suspended", chg, 2'b01);
        step(); check_all("R7 pulse ends");
        check("R7", "pulse one cycle", chg, 2'b00);
        cc = 2'b11; step(); step();
        // R6: bias rise resumes
        bd = 2'b01; step(); check_all("R6 bias");
        check("R6", "bias rise resumes", susp, 2'b00);
        // R6: resume request
        bd = 2'b00; sreq = 2'b10; step(); sreq = '0;
        check("R5", "port1 suspended", susp, 2'b10);
        rreq = 2'b10; step(); rreq = '0;
        check_all("R6 resume");
        check("R6", "resume request", susp, 2'b00);
        // R9: power-down while suspended goes to off, then back to running
        sreq = 2'b11; step(); sreq = '0;
        pd = 1'b1; #1 check("R9", "pd gates bias at once", bias, '0);
        step(); pd = 1'b0; check_all("R9 pd release");
        check("R9", "off after pd", susp, '0);
        step(); check_all("R9 run");
        check("R9", "running not suspended", tx, 2'b11);
        // R2: link disable gates bias only on its port
        link = 2'b10; check_all("R2 link"); check("R2", "link gates bias", bias, 2'b01);
        step(); link = '0; step();
        // R8: asynchronous reset mid-run
        rst_n = 1'b0; model_reset(); rcnt = 0;
        check_all("R8 async");
        check("R8", "async clear", tx | bias, '0);
        step(); rst_n = 1'b1;

        // random phase
        for (int n = 0; n < 4000; n++) begin
            pd   = ($urandom % 24) == 0;
            rst_n = ($urandom % 400) != 0;
            if (!rst_n) begin model_reset(); rcnt = 0; end
            for (int i = 0; i < NP; i++) begin
                if ($urandom % 6 == 0) cc[i] = ~cc[i];
                if ($urandom % 5 == 0) bd[i] = ~bd[i];
                arb[i]  = ($urandom % 8) == 0;
                link[i] = ($urandom % 20) == 0;
                sreq[i] = ($urandom % 6) == 0;
                rreq[i] = ($urandom % 10) == 0;
            end
            check_all("random R5 R6 R8 R9");
            step();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule